// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block plays the part of a 256-byte, 8-bit-wide serial EEPROM on a two-wire bus whose lines are driven in software. The host hands it one sample of the clock and data line levels per write strobe. The block keeps the previous levels and compares each new sample against them. From that comparison it finds start and stop conditions and clock rising edges. It then answers with a data line level that the host reads back.

After a start condition, the block takes a device byte most significant bit first and acknowledges it. Bit 0 of that byte is the read flag. It then takes a word address byte. While the address is arriving, and only when the read flag is set, each address clock edge puts the most significant bit of the data register on the line, and the register shifts left. Once the address byte is complete, the register is loaded from memory at that address and a second acknowledge follows. The block then goes idle until the next start.

Memory contents come from a parameter image. By default the byte at address a is (37·a + 11) mod 256. Nothing writes to the memory.

Top module: `i2cee_slave`

## Requirements
- R1: After reset `sdaOut` is 1, and `sdaOut` changes only in a cycle where `wrStb` is high.
- R2: A sample with SCL high both before and now, and SDA falling from 1 to 0, is a start. It restarts the device byte count and clears the device byte.
- R3: A sample with SCL high both before and now, and SDA rising from 0 to 1, is a stop. It changes no count and no pending acknowledge, and `sdaOut` follows the host level.
- R4: While no transfer is active and no acknowledge is pending, every sample other than a start has no effect, and `sdaOut` mirrors `sdaIn`.
- R5: A bit is accepted only on an SCL rising sample (0 then 1) whose SDA equals the previous SDA. A rising sample where SDA also changed is discarded.
- R6: After the 8th device bit, the next SCL rising sample drives `sdaOut` to 0 whatever the host drives, and that sample carries no data bit.
- R7: During the 8 address bits, if bit 0 of the device byte is 1, `sdaOut` on each accepted rising sample is the data register's MSB and the register shifts left. If bit 0 is 0, `sdaOut` mirrors `sdaIn`.
- R8: The address is taken MSB first. After its 8th bit, the data register is loaded from memory at that address and the next rising sample drives `sdaOut` to 0.
- R9: A following read transfer shifts the fetched byte out MSB first on its 8 address clock edges.
- R10: After the acknowledge that follows the address byte, the block is idle: bits without a start give no acknowledge.
- R11: A start that arrives while an acknowledge is pending keeps that acknowledge pending, so the next rising sample drives 0. The device byte count still restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle strobe that presents a new line sample |
| sclIn | input | 1 | Clock line level of this sample |
| sdaIn | input | 1 | Data line level the host drives in this sample |
| sdaOut | output | 1 | Data line level the responder presents for read-back |

## Verification
Two functions fall on the same strobe when the last address bit arrives. On that strobe the address register takes its final bit, the data register is reloaded from memory instead of shifted, and an acknowledge becomes pending. The bench provokes this with back-to-back read transfers. The byte fetched at the end of one transfer must appear MSB first on the address edges of the next one. A start that lands while an acknowledge is pending is also provoked, and is judged by where the acknowledge and the following one fall. A behavioural model in the bench tracks the output level on every clock.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  // Widest memory image the seed function can build.
  localparam int IMG_MAX = 16384;

  // Per-sample strobes from the control to the datapath.
  typedef struct packed {
    logic capture;    // a sample is being taken
    logic clearCmd;   // start seen: clear the device byte
    logic shiftCmd;   // accept a device byte bit
    logic shiftAddr;  // accept an address bit, shift data
    logic fetch;      // last address bit: load data from memory
    logic ackLow;     // acknowledge slot: drive the line low
  } eeStrobe_t;

  // Default memory image: byte a holds 37*a + 11, truncated.
  function automatic logic [IMG_MAX-1:0] seedImage(input int addrBits, input int dataBits);
    logic [IMG_MAX-1:0] img;
    int val;
    img = '0;
    for (int a = 0; a < (1 << addrBits); a++) begin
      val = a * 37 + 11;
      for (int b = 0; b < dataBits; b++) begin
        if (a * dataBits + b < IMG_MAX) img[a * dataBits + b] = val[b];
      end
    end
    return img;
  endfunction

endpackage

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStb,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       sdaLast,
  output eeStrobe_t  stb
);

  localparam int CMD_END  = CMD_W + 1;
  localparam int ADDR_END = CMD_W + ADDR_W + 1;
  localparam int TICK_W   = $clog2(ADDR_END + 1);
  localparam logic [TICK_W-1:0] TK_ONE       = TICK_W'(1);
  localparam logic [TICK_W-1:0] TK_CMD_END   = TICK_W'(CMD_END);
  localparam logic [TICK_W-1:0] TK_CMD_LAST  = TICK_W'(CMD_END - 1);
  localparam logic [TICK_W-1:0] TK_ADDR_END  = TICK_W'(ADDR_END);
  localparam logic [TICK_W-1:0] TK_ADDR_LAST = TICK_W'(ADDR_END - 1);

  logic [TICK_W-1:0] tick;
  logic ackPend;
  logic sclLast;

  logic busCond, startCond, idle, sclRise, ackSlot, bitValid;
  logic cmdBit, addrBit, cmdDone, addrDone;

  always_comb begin
    busCond   = wrStb && sclLast && sclIn && (sdaLast != sdaIn);
    startCond = busCond && !sdaIn;
    idle      = (tick == '0) && !ackPend;
    sclRise   = wrStb && !busCond && !idle && !sclLast && sclIn;
    ackSlot   = sclRise && ackPend;
    bitValid  = sclRise && !ackPend && (sdaLast == sdaIn);
    cmdBit    = bitValid && (tick < TK_CMD_END);
    addrBit   = bitValid && (tick >= TK_CMD_END) && (tick < TK_ADDR_END);
    cmdDone   = cmdBit && (tick == TK_CMD_LAST);
    addrDone  = addrBit && (tick == TK_ADDR_LAST);
  end

  always_comb begin
    stb.capture   = wrStb;
    stb.clearCmd  = startCond;
    stb.shiftCmd  = cmdBit;
    stb.shiftAddr = addrBit;
    stb.fetch     = addrDone;
    stb.ackLow    = ackSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick    <= '0;
      ackPend <= 1'b0;
      sclLast <= 1'b1;
    end else begin
      if (wrStb) sclLast <= sclIn;
      if (startCond)    tick <= TK_ONE;
      else if (cmdBit)  tick <= tick + TK_ONE;
      else if (addrBit) tick <= addrDone ? '0 : tick + TK_ONE;
      if (ackSlot)                    ackPend <= 1'b0;
      else if (cmdDone || addrDone)   ackPend <= 1'b1;
    end
  end

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rstN) startCond |=> (tick == TK_ONE)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) (idle && !startCond) |=> ((tick == '0) && !ackPend)); // R4
  AST_ACK_ONE_SLOT: assert property (@(posedge clk) disable iff (!rstN) ackSlot |=> !ackPend); // R6
  AST_FETCH_RETURNS: assert property (@(posedge clk) disable iff (!rstN) addrDone |=> (ackPend && (tick == '0))); // R8
  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rstN) tick < TK_ADDR_END); // R8
  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rstN) (ackPend && startCond) |=> ackPend); // R11

endmodule

// File: rtl/i2cee_dpath.sv
module i2cee_dpath
  import i2cee_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W*(2**ADDR_W)-1:0] MEM_IMAGE = '0
) (
  input  logic      clk,
  input  logic      rstN,
  input  eeStrobe_t stb,
  input  logic      sdaIn,
  output logic      sdaOut
);

  logic [CMD_W-1:0]  cmdReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              sdaReg;

  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] romByte;

  always_comb begin
    addrNext = {addrReg[ADDR_W-2:0], sdaIn};
    romByte  = MEM_IMAGE[int'(addrNext) * DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      dataReg <= '0;
      sdaReg  <= 1'b1;
    end else if (stb.capture) begin
      if (stb.clearCmd)      cmdReg <= '0;
      else if (stb.shiftCmd) cmdReg <= {cmdReg[CMD_W-2:0], sdaIn};
      if (stb.shiftAddr) begin
        addrReg <= addrNext;
        dataReg <= stb.fetch ? romByte : {dataReg[DATA_W-2:0], 1'b0};
      end
      if (stb.ackLow)                       sdaReg <= 1'b0;
      else if (stb.shiftAddr && cmdReg[0])  sdaReg <= dataReg[DATA_W-1];
      else                                  sdaReg <= sdaIn;
    end
  end

  assign sdaOut = sdaReg;

  AST_ACK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rstN) stb.ackLow |=> !sdaOut); // R6
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN) !stb.capture |=> $stable(sdaOut)); // R1
  AST_READ_MSB_ZERO: assert property (@(posedge clk) disable iff (!rstN) (stb.shiftAddr && cmdReg[0] && !dataReg[DATA_W-1]) |=> !sdaOut); // R7
  AST_READ_MSB_ONE: assert property (@(posedge clk) disable iff (!rstN) (stb.shiftAddr && cmdReg[0] && dataReg[DATA_W-1]) |=> sdaOut); // R7

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W*(2**ADDR_W)-1:0] MEM_IMAGE =
    (DATA_W*(2**ADDR_W))'(seedImage(ADDR_W, DATA_W))
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrStb,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOut
);

  eeStrobe_t stb;

  i2cee_ctrl #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .sdaLast (sdaOut),
    .stb     (stb)
  );

  i2cee_dpath #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_IMAGE(MEM_IMAGE)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .sdaIn  (sdaIn),
    .sdaOut (sdaOut)
  );

endmodule

// File: tb/sim_i2cee_slave.sv
module sim_i2cee_slave;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic sdaOut;

  always #4 clk = ~clk;  // 125 MHz

  i2cee_slave u0 (
    .clk    (clk),
    .rstN   (rstN),
    .wrStb  (wrStb),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .sdaOut (sdaOut)
  );

  int nVec = 0;
  int nBad = 0;
  string curReq = "R1";
  bit done = 1'b0;

  // Behavioural reference, stepped once per strobe.
  int mScl, mSda, mPhaseBits, mAckOwed, mDev, mWord, mShift;

  function automatic int seedOf(input int a);
    return (a * 37 + 11) % 256;
  endfunction

  always @(posedge clk) begin
    int outLvl;
    if (!rstN) begin
      mScl = 1; mSda = 1; mPhaseBits = 0; mAckOwed = 0; mDev = 0; mWord = 0; mShift = 0;
    end else if (wrStb) begin
      outLvl = int'(sdaIn);
      if (mScl == 1 && sclIn && mSda != int'(sdaIn)) begin
        if (!sdaIn) begin mPhaseBits = 1; mDev = 0; end
      end else if ((mPhaseBits != 0 || mAckOwed != 0) && mScl == 0 && sclIn) begin
        if (mAckOwed != 0) begin
          outLvl = 0; mAckOwed = 0;
        end else if (mSda == int'(sdaIn)) begin
          if (mPhaseBits < 9) begin
            mDev = (mDev * 2 + int'(sdaIn)) % 256;
            mPhaseBits++;
            if (mPhaseBits == 9) mAckOwed = 1;
          end else begin
            if (mDev % 2 == 1) outLvl = (mShift / 128) % 2;
            mWord = (mWord * 2 + int'(sdaIn)) % 256;
            mShift = (mShift * 2) % 256;
            mPhaseBits++;
            if (mPhaseBits == 17) begin
              mShift = seedOf(mWord); mAckOwed = 1; mPhaseBits = 0;
            end
          end
        end
      end
      mScl = int'(sclIn);
      mSda = outLvl;
    end
  end

  // Compare against the model on every clock.
  always @(negedge clk) begin
    if (rstN && !done) begin
      nVec++;
      if (sdaOut !== mSda[0]) begin
        nBad++;
        $display("FAIL %s model compare actual=%b expected=%b", curReq, sdaOut, mSda[0]);
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic strobe(input logic s, input logic d);
    @(negedge clk);
    wrStb = 1'b1; sclIn = s; sdaIn = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic bitChk(input logic b, input logic exp, input string req);
    strobe(1'b0, b);
    strobe(1'b1, b);
    check(req, sdaOut, exp);
  endtask

  task automatic byteOut(input logic [7:0] host, input logic [7:0] outv, input string req);
    for (int i = 7; i >= 0; i--) bitChk(host[i], outv[i], req);
  endtask

  task automatic startCond();
    strobe(1'b1, 1'b1);
    strobe(1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nBad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check("R1 reset level", sdaOut, 1'b1);
    repeat (3) @(negedge clk);
    check("R1 no strobe hold", sdaOut, 1'b1);

    // R4: bits without a start are ignored
    curReq = "R4";
    byteOut(8'hA0, 8'hA0, "R4");
    bitChk(1'b1, 1'b1, "R4 no ack");

    // R2 and R6: device byte with read flag then acknowledge
    curReq = "R2";
    startCond();
    byteOut(8'hA1, 8'hA1, "R2");
    curReq = "R6";
    bitChk(1'b1, 1'b0, "R6 ack");

    // R7: read flag drives data MSB (data is zero after reset)
    curReq = "R7";
    byteOut(8'h3C, 8'h00, "R7 read zero");
    curReq = "R8";
    bitChk(1'b1, 1'b0, "R8 ack");

    // R10: idle after address acknowledge
    curReq = "R10";
    byteOut(8'hA1, 8'hA1, "R10");
    bitChk(1'b1, 1'b1, "R10 no ack");

    // R9: fetched byte at 0x3C shifts out on the next read
    curReq = "R9";
    startCond();
    byteOut(8'hA1, 8'hA1, "R9");
    bitChk(1'b1, 1'b0, "R6 ack read");
    byteOut(8'h00, 8'(seedOf(8'h3C)), "R9 readback");
    bitChk(1'b1, 1'b0, "R8 ack");

    // R7: write flag mirrors host on address bits
    curReq = "R7";
    startCond();
    byteOut(8'hA0, 8'hA0, "R7");
    bitChk(1'b1, 1'b0, "R6 ack write");
    byteOut(8'h55, 8'h55, "R7 mirror");
    bitChk(1'b1, 1'b0, "R8 ack");

    // R8: address 0x55 taken MSB first and fetched
    curReq = "R8";
    startCond();
    byteOut(8'hA1, 8'hA1, "R8");
    bitChk(1'b1, 1'b0, "R6 ack");
    byteOut(8'hFF, 8'(seedOf(8'h55)), "R8 fetched");
    bitChk(1'b1, 1'b0, "R8 ack");

    // R5: a rising edge with changing SDA is discarded
    curReq = "R5";
    startCond();
    bitChk(1'b1, 1'b1, "R5"); bitChk(1'b0, 1'b0, "R5"); bitChk(1'b1, 1'b1, "R5");
    strobe(1'b0, 1'b0);
    strobe(1'b1, 1'b1);
    check("R5 glitch mirror", sdaOut, 1'b1);
    bitChk(1'b0, 1'b0, "R5"); bitChk(1'b0, 1'b0, "R5");
    bitChk(1'b0, 1'b0, "R5"); bitChk(1'b0, 1'b0, "R5");
    bitChk(1'b1, 1'b1, "R5 eighth bit");
    bitChk(1'b1, 1'b0, "R5 ack position");

    // R3: stop in mid-byte changes no count
    curReq = "R3";
    startCond();
    bitChk(1'b1, 1'b1, "R3"); bitChk(1'b0, 1'b0, "R3");
    bitChk(1'b1, 1'b1, "R3"); bitChk(1'b0, 1'b0, "R3");
    strobe(1'b1, 1'b1);
    check("R3 stop level", sdaOut, 1'b1);
    bitChk(1'b0, 1'b0, "R3"); bitChk(1'b0, 1'b0, "R3");
    bitChk(1'b0, 1'b0, "R3"); bitChk(1'b1, 1'b1, "R3");
    bitChk(1'b1, 1'b0, "R3 ack kept");

    // R11: start while acknowledge pending
    curReq = "R11";
    startCond();
    byteOut(8'hA1, 8'hA1, "R11");
    startCond();
    bitChk(1'b1, 1'b0, "R11 pending ack");
    byteOut(8'hA0, 8'hA0, "R11");
    bitChk(1'b1, 1'b0, "R11 restarted count");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule